// File: doc/BRIEF.md
# Memory Address/Data Register Interface Unit

This unit sits between a processor's single internal data bus and an external word-wide memory. It has two registers. The address register is loaded from the internal bus, and its contents drive the external address lines; it only carries data in that one direction. The data register is a two-sided buffer. It has two load paths: one from the internal bus and one from the external data lines. It also has two drive paths: onto the internal bus and onto the external write-data lines. Each of the four paths has its own enable.

The processor's control logic issues a read or a write request. The unit then holds the matching memory strobe until the memory reports completion. Until that happens, the unit raises a stall toward the control logic. A load runs in three steps:
1. Place the address and request a read.
2. Keep the external-capture enable high while waiting.
3. Drive the data register onto the internal bus.

A store runs as follows:
1. Place the address.
2. Load the data register and request a write.
3. Drive the data register outward while waiting.

The internal bus stays usable while an access is pending. A second request during a pending access is not accepted and is reported on an error pulse.

Top module: `mem_port_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, stall, err, mem_rd, mem_wr, ibus_out_en and mem_wdata_en are all 0, and mem_addr reads 0.
- R2: A clock edge with mar_ld high loads ibus_in into the address register, and mem_addr shows the new value from the next cycle on. With mar_ld low, mem_addr does not change.
- R3: A clock edge with mdr_ld_int high (and no external capture) loads ibus_in into the data register. ibus_out always carries the data register, and ibus_out_en equals mdr_drv_int in the same cycle. mem_wdata carries the data register, and mem_wdata_en equals mdr_drv_ext. With no load enable, the data register holds its value.
- R4: A read request accepted while idle sets mem_rd high from the next cycle. mem_rd stays high through the cycle in which mem_done is high and is low in the cycle after that.
- R5: The same timing as R4 applies to a write request and mem_wr. The memory receives mem_wdata at mem_addr in the completion cycle.
- R6: stall is high in the cycle a valid request is presented and in every cycle of a pending access while mem_done is low. stall is low in the cycle in which mem_done is high.
- R7: A read or write request presented while an access is pending is ignored: the strobes and the data of the pending access are unchanged. err is high for exactly the following cycle.
- R8: Read and write requested in the same idle cycle start no access and do not raise stall. err is high for the following cycle.
- R9: In a read's completion cycle with mdr_ld_ext high, the data register takes mem_data_in, even if mdr_ld_int is high in the same cycle.
- R10: During a pending access, mdr_drv_int still places the current data register value on ibus_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ibus_in | input | DW | Value currently on the internal bus |
| mar_ld | input | 1 | Load address register from the internal bus |
| mdr_ld_int | input | 1 | Load data register from the internal bus |
| mdr_ld_ext | input | 1 | Capture external read data at read completion |
| mdr_drv_int | input | 1 | Drive data register onto the internal bus |
| mdr_drv_ext | input | 1 | Drive data register onto the external data lines |
| rd_req | input | 1 | Start a memory read |
| wr_req | input | 1 | Start a memory write |
| mem_data_in | input | DW | Read data from memory |
| mem_done | input | 1 | Memory function completed |
| ibus_out | output | DW | Data register value toward the internal bus |
| ibus_out_en | output | 1 | Internal bus drive enable |
| mem_addr | output | DW | External address lines |
| mem_wdata | output | DW | Data register value toward memory |
| mem_wdata_en | output | 1 | External data drive enable |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| stall | output | 1 | Hold the control sequence |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong access state shows up within one cycle, in one of three ways: a strobe stays up after completion, both strobes are up together, or stall is still high when mem_done arrives. In each case the controller waits on a memory that has already finished. A corrupt data register appears on ibus_out as soon as drive is enabled after the completion cycle, so every load is compared against a shadow of memory contents. A request that should have been refused would instead show a strobe change or a wrong value read back in the next read of that address.

// File: rtl/mif_pkg.sv
package mif_pkg;

  // Pending access kind held by the access controller
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } mif_op_e;

endpackage

// File: rtl/mif_addr_reg.sv
module mif_addr_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  logic [DW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (ld) begin
      addr_q <= din;
    end
  end

  // Address lines are driven straight from the register
  assign q = addr_q;

endmodule

// File: rtl/mif_data_buf.sv
module mif_data_buf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_int,
  input  logic [DW-1:0] din_int,
  input  logic          cap_ext,
  input  logic [DW-1:0] din_ext,
  output logic [DW-1:0] q
);

  logic [DW-1:0] data_q;
  logic [DW-1:0] data_d;

  // External capture wins over an internal load in the same cycle
  always_comb begin
    data_d = data_q;
    if (cap_ext) begin
      data_d = din_ext;
    end else if (ld_int) begin
      data_d = din_int;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign q = data_q;

endmodule

// File: rtl/mif_access_ctrl.sv
module mif_access_ctrl
  import mif_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic wr_req,
  input  logic mfc,
  output logic mem_rd,
  output logic mem_wr,
  output logic stall,
  output logic err,
  output logic rd_done
);

  mif_op_e op_q;
  mif_op_e op_d;
  logic    idle;
  logic    any_req;
  logic    clash;
  logic    refuse;
  logic    err_q;

  always_comb begin
    idle    = (op_q == OP_IDLE);
    any_req = rd_req | wr_req;
    clash   = rd_req & wr_req;
    refuse  = (!idle && any_req) || (idle && clash);
  end

  always_comb begin
    op_d = op_q;
    if (idle) begin
      if (rd_req && !wr_req) begin
        op_d = OP_READ;
      end else if (wr_req && !rd_req) begin
        op_d = OP_WRITE;
      end
    end else if (mfc) begin
      op_d = OP_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_IDLE;
      err_q <= 1'b0;
    end else begin
      op_q  <= op_d;
      err_q <= refuse;
    end
  end

  assign mem_rd  = (op_q == OP_READ);
  assign mem_wr  = (op_q == OP_WRITE);
  assign err     = err_q;
  assign rd_done = mem_rd & mfc;
  // Held from the issue cycle until completion is seen
  assign stall   = (idle & (rd_req ^ wr_req)) | (!idle & !mfc);

endmodule

// File: rtl/mem_port_unit.sv
module mem_port_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ibus_in,
  input  logic          mar_ld,
  input  logic          mdr_ld_int,
  input  logic          mdr_ld_ext,
  input  logic          mdr_drv_int,
  input  logic          mdr_drv_ext,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic [DW-1:0] mem_data_in,
  input  logic          mem_done,
  output logic [DW-1:0] ibus_out,
  output logic          ibus_out_en,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_en,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          stall,
  output logic          err
);

  logic          rd_done;
  logic          cap_ext;
  logic [DW-1:0] mdr_q;

  mif_addr_reg #(.DW(DW)) u_addr (
    .clk (clk),
    .rst (rst),
    .ld  (mar_ld),
    .din (ibus_in),
    .q   (mem_addr)
  );

  mif_access_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_req  (wr_req),
    .mfc     (mem_done),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .stall   (stall),
    .err     (err),
    .rd_done (rd_done)
  );

  assign cap_ext = mdr_ld_ext & rd_done;

  mif_data_buf #(.DW(DW)) u_data (
    .clk     (clk),
    .rst     (rst),
    .ld_int  (mdr_ld_int),
    .din_int (ibus_in),
    .cap_ext (cap_ext),
    .din_ext (mem_data_in),
    .q       (mdr_q)
  );

  assign ibus_out     = mdr_q;
  assign ibus_out_en  = mdr_drv_int;
  assign mem_wdata    = mdr_q;
  assign mem_wdata_en = mdr_drv_ext;

endmodule

// File: rtl/mif_checker.sv
module mif_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mar_ld,
  input logic          mdr_ld_int,
  input logic          mdr_ld_ext,
  input logic          rd_req,
  input logic          wr_req,
  input logic          mem_done,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          stall,
  input logic          err
);

  // R2
  mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mar_ld |=> $stable(mem_addr));

  // R3
  mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mdr_ld_int && !mdr_ld_ext) |=> $stable(mem_wdata));

  // R4
  strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_done) |=> (!mem_rd && !mem_wr));

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R6
  stall_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_done) |-> stall);

  // R6
  stall_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_done) |-> !stall);

  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && (rd_req || wr_req)) |=> err);

  // R8
  clash_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd && !mem_wr && rd_req && wr_req) |=> (!mem_rd && !mem_wr && err));

endmodule

bind mem_port_unit mif_checker #(.DW(DW)) u_mif_chk (
  .clk        (clk),
  .rst        (rst),
  .mar_ld     (mar_ld),
  .mdr_ld_int (mdr_ld_int),
  .mdr_ld_ext (mdr_ld_ext),
  .rd_req     (rd_req),
  .wr_req     (wr_req),
  .mem_done   (mem_done),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .stall      (stall),
  .err        (err)
);

// File: tb/mif_mem_model.sv
module mif_mem_model #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    lat,
  input  logic [DW-1:0] mem_addr,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic [DW-1:0] mem_wdata,
  input  logic          mem_wdata_en,
  output logic [DW-1:0] mem_data_in,
  output logic          mem_done
);

  logic [DW-1:0] store [16];
  logic          active;
  logic [2:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      mem_done <= 1'b0;
      for (int i = 0; i < 16; i++) store[i] <= DW'(i * 16'h1111 + 16'h0F0F);
    end else begin
      mem_done <= 1'b0;
      if (mem_done && mem_wr && mem_wdata_en) store[mem_addr[3:0]] <= mem_wdata;
      if (active) begin
        if (cnt == 0) begin
          mem_done <= 1'b1;
          active   <= 1'b0;
        end else begin
          cnt <= cnt - 3'd1;
        end
      end else if ((mem_rd || mem_wr) && !mem_done) begin
        active <= 1'b1;
        cnt    <= lat;
      end
    end
  end

  assign mem_data_in = mem_done ? store[mem_addr[3:0]] : '0;

endmodule

// File: tb/test_mem_port_unit.sv
module test_mem_port_unit;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] ibus_in = '0;
  logic          mar_ld = 0, mdr_ld_int = 0, mdr_ld_ext = 0;
  logic          mdr_drv_int = 0, mdr_drv_ext = 0, rd_req = 0, wr_req = 0;
  logic [DW-1:0] mem_data_in, ibus_out, mem_addr, mem_wdata;
  logic          mem_done, ibus_out_en, mem_wdata_en, mem_rd, mem_wr, stall, err;
  logic [2:0]    lat = 3'd3;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [16];

  always #10 clk = ~clk;

  mem_port_unit #(.DW(DW)) i_mem_port_unit (
    .clk(clk), .rst(rst), .ibus_in(ibus_in), .mar_ld(mar_ld),
    .mdr_ld_int(mdr_ld_int), .mdr_ld_ext(mdr_ld_ext),
    .mdr_drv_int(mdr_drv_int), .mdr_drv_ext(mdr_drv_ext),
    .rd_req(rd_req), .wr_req(wr_req), .mem_data_in(mem_data_in),
    .mem_done(mem_done), .ibus_out(ibus_out), .ibus_out_en(ibus_out_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .stall(stall), .err(err)
  );

  mif_mem_model #(.DW(DW)) u_mem (
    .clk(clk), .rst(rst), .lat(lat), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en),
    .mem_data_in(mem_data_in), .mem_done(mem_done)
  );

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(i * 16'h1111 + 16'h0F0F);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Load sequence; optional internal load clutter, refused write, or drive during wait
  task automatic do_load(input logic [DW-1:0] addr, input bit clutter, input bit poke,
                         input bit drv_wait, input logic [DW-1:0] pre,
                         output logic [DW-1:0] got);
    bit seen = 0;
    @(negedge clk);
    ibus_in = addr; mar_ld = 1; rd_req = 1;
    #1 chk("R6 stall in issue cycle", stall, 1);
    @(negedge clk);
    mar_ld = 0; rd_req = 0; mdr_ld_ext = 1;
    if (clutter) begin mdr_ld_int = 1; ibus_in = 16'hDEAD; end
    if (poke) wr_req = 1;
    if (drv_wait) mdr_drv_int = 1;
    for (int i = 0; i < 64; i++) begin
      #1;
      if (!stall) begin
        chk("R6 stall low only with mem_done", mem_done, 1);
        seen = 1;
        break;
      end
      if (i == 0) begin
        chk("R4 mem_rd during wait", mem_rd, 1);
        if (drv_wait) chk("R10 drive during pending", ibus_out, pre);
      end
      @(negedge clk);
      if (poke && i == 0) begin
        wr_req = 0;
        #1 chk("R7 err after refused request", err, 1);
        chk("R7 no write strobe", mem_wr, 0);
      end
    end
    if (!seen) chk("R6 completion seen", 0, 1);
    @(negedge clk);
    mdr_ld_ext = 0; mdr_ld_int = 0; mdr_drv_int = 1;
    #1 chk("R4 mem_rd released", mem_rd, 0);
    chk("R3 ibus_out_en", ibus_out_en, 1);
    got = ibus_out;
    @(negedge clk);
    mdr_drv_int = 0;
  endtask

  task automatic do_store(input logic [DW-1:0] addr, input logic [DW-1:0] data);
    bit seen = 0;
    @(negedge clk);
    ibus_in = addr; mar_ld = 1;
    @(negedge clk);
    mar_ld = 0; ibus_in = data; mdr_ld_int = 1; wr_req = 1;
    #1 chk("R6 stall in write issue cycle", stall, 1);
    @(negedge clk);
    mdr_ld_int = 0; wr_req = 0; mdr_drv_ext = 1;
    for (int i = 0; i < 64; i++) begin
      #1;
      if (!stall) begin seen = 1; break; end
      if (i == 0) begin
        chk("R5 mem_wr during wait", mem_wr, 1);
        chk("R2 address held", mem_addr, addr);
        chk("R3 mem_wdata", mem_wdata, data);
      end
      @(negedge clk);
    end
    if (!seen) chk("R5 completion seen", 0, 1);
    @(negedge clk);
    mdr_drv_ext = 0;
    #1 chk("R5 mem_wr released", mem_wr, 0);
    shadow[addr[3:0]] = data;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) shadow[i] = init_word(i);

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 stall", stall, 0); chk("R1 err", err, 0);
    chk("R1 mem_rd", mem_rd, 0); chk("R1 mem_wr", mem_wr, 0);
    chk("R1 mem_addr", mem_addr, 0);
    chk("R1 drive enables", {ibus_out_en, mem_wdata_en}, 0);
    @(negedge clk); rst = 0;
    #1 chk("R1 stall after reset", stall, 0);

    // R2 address register load and hold
    @(negedge clk); ibus_in = 16'h00A5; mar_ld = 1;
    @(negedge clk); mar_ld = 0; ibus_in = 16'hFFFF;
    #1 chk("R2 load", mem_addr, 16'h00A5);
    @(negedge clk);
    #1 chk("R2 hold", mem_addr, 16'h00A5);

    // R3 internal load and both drive paths
    @(negedge clk); ibus_in = 16'h1234; mdr_ld_int = 1;
    @(negedge clk); mdr_ld_int = 0; ibus_in = 16'h0; mdr_drv_int = 1;
    #1 chk("R3 ibus_out", ibus_out, 16'h1234);
    chk("R3 ibus_out_en", ibus_out_en, 1);
    chk("R3 wdata_en off", mem_wdata_en, 0);
    mdr_drv_ext = 1; mdr_drv_int = 0;
    #1 chk("R3 mem_wdata", mem_wdata, 16'h1234);
    chk("R3 wdata_en", mem_wdata_en, 1);
    chk("R3 ibus_out_en off", ibus_out_en, 0);
    @(negedge clk); mdr_drv_ext = 0;
    #1 chk("R3 hold", ibus_out, 16'h1234);

    // R4 plain read of initial contents
    do_load(16'h0003, 0, 0, 0, 0, got);
    chk("R4 read data", got, shadow[3]);

    // R5 write then read back
    do_store(16'h0007, 16'hBEEF);
    do_load(16'h0007, 0, 0, 0, 0, got);
    chk("R5 readback", got, 16'hBEEF);

    // R9 external capture beats internal load
    do_load(16'h0005, 1, 0, 0, 0, got);
    chk("R9 capture priority", got, shadow[5]);

    // R7 refused write during pending read
    do_load(16'h0009, 0, 1, 0, 0, got);
    chk("R7 read data intact", got, shadow[9]);
    do_load(16'h0009, 0, 0, 0, 0, got);
    chk("R7 memory untouched", got, shadow[9]);

    // R10 drive during pending access
    @(negedge clk); ibus_in = 16'h5A5A; mdr_ld_int = 1;
    @(negedge clk); mdr_ld_int = 0;
    do_load(16'h000A, 0, 0, 1, 16'h5A5A, got);
    chk("R10 final data", got, shadow[10]);

    // R8 simultaneous read and write
    @(negedge clk); rd_req = 1; wr_req = 1;
    #1 chk("R8 no stall", stall, 0);
    @(negedge clk); rd_req = 0; wr_req = 0;
    #1 chk("R8 err", err, 1);
    chk("R8 no strobes", {mem_rd, mem_wr}, 0);
    @(negedge clk);
    #1 chk("R8 err one cycle", err, 0);

    // Random mix with varying memory latency
    for (int n = 0; n < 40; n++) begin
      logic [DW-1:0] a;
      logic [DW-1:0] d;
      lat = 3'($urandom % 5);
      a = DW'($urandom % 16);
      d = DW'($urandom);
      if ($urandom % 2) begin
        do_store(a, d);
      end else begin
        do_load(a, ($urandom % 2) == 1, 0, 0, 0, got);
        chk("R4 random read", got, shadow[a[3:0]]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule